// File: doc/BRIEF.md
# Pointer-Pair Scatter DMA Engine

This engine moves 32-bit words from an inbound bus port into local memory. Each block is described by a pair of byte addresses, a lower start and a higher stop, and the stop is inclusive. Software loads a queue of such pairs while the engine is idle and then issues a start pulse. The engine takes the pairs one after another and writes the incoming words to consecutive word addresses across each range. When the last pair is finished it raises an interrupt.

Because every block has its own address range, the word stream can be split without processor help. If the pairs alternate between a header area and a payload area, the header words land in one list and the payload words land in another. The memory side is a simple valid/ready write port. The byte size of the window that is currently open can be read on a status output. Pair addresses are treated as word aligned: bits 1:0 are ignored.

Top module: `ptr_dma`

## Requirements
- R1: After reset the engine is idle. busy, irq, err_empty and err_range are 0, pairs_left is 0, and mem_valid and in_ready are 0.
- R2: A pair_push while idle stores one pair and increments pairs_left, up to DEPTH (8) pairs. A push when the queue is full, or while busy, is ignored and pairs_left does not change.
- R3: Within a block, words are written to start, start+4, and so on up to and including stop. The data is passed to memory in arrival order.
- R4: Outside a transfer, mem_valid and in_ready are 0. During a transfer, mem_valid follows in_valid, in_ready follows mem_ready, and mem_data equals in_data.
- R5: Pairs are used in the order they were loaded. Between the last word of one block and the first word of the next there is exactly one idle cycle.
- R6: When pairs alternate between two address regions, the words of successive blocks go to their own regions, and each region is filled contiguously.
- R7: irq rises in the same cycle in which busy falls, after the last word of the last pair. irq stays at 1 until the next accepted go.
- R8: A go with an empty queue sets err_empty, transfers nothing, and leaves the engine idle.
- R9: A pair whose stop is below its start sets err_range. No word is transferred, the engine returns to idle and the queue is cleared.
- R10: From the first transfer cycle of a block, win_bytes equals stop - start + 4. This is 4 for a single word and 2^24 for the whole space.
- R11: A go while busy is ignored. An accepted go clears irq, err_empty and err_range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_push | input | 1 | Store pair_lo/pair_hi into the queue |
| pair_lo | input | 24 | Block start byte address |
| pair_hi | input | 24 | Block stop byte address (inclusive) |
| go | input | 1 | Start processing the queued pairs |
| busy | output | 1 | Engine is loading or transferring |
| irq | output | 1 | All pairs are done (sticky) |
| err_empty | output | 1 | go was given with an empty queue |
| err_range | output | 1 | A pair with stop below start was met |
| pairs_left | output | 4 | Number of pairs waiting in the queue |
| win_bytes | output | 25 | Byte size of the current window |
| in_valid | input | 1 | Inbound word available |
| in_data | input | 32 | Inbound word |
| in_ready | output | 1 | Inbound word accepted |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 24 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |

## Verification
Some behaviour is checked by the assertions on every cycle:
- The handshake is silent when the engine is idle.
- Addresses step by four within a block and never leave the open window.
- The queue count stays within its depth.
- irq and err_empty rise only once the engine is idle.

Other behaviour can only be shown by the bench's scenarios: the order in which pairs are used, the single idle cycle between blocks, the split of headers and payload under a stalling memory, the window size, and the ignoring of pushes and go pulses while busy.

// File: rtl/ptr_dma.sv
module ptr_dma #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pair_push,
  input  logic [AW-1:0]              pair_lo,
  input  logic [AW-1:0]              pair_hi,
  input  logic                       go,
  output logic                       busy,
  output logic                       irq,
  output logic                       err_empty,
  output logic                       err_range,
  output logic [$clog2(DEPTH):0]     pairs_left,
  output logic [AW:0]                win_bytes,
  input  logic                       in_valid,
  input  logic [DW-1:0]              in_data,
  output logic                       in_ready,
  output logic                       mem_valid,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_data,
  input  logic                       mem_ready
);
  localparam int WW = AW - 2;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  typedef enum logic [1:0] {IDLE, LOAD, XFER} st_t;
  st_t st;

  logic [WW-1:0] q_lo [DEPTH];
  logic [WW-1:0] q_hi [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic [WW-1:0] cur, stop_w;

  wire [WW-1:0] head_lo = q_lo[rd_p];
  wire [WW-1:0] head_hi = q_hi[rd_p];
  wire          bad     = head_hi < head_lo;
  wire [WW:0]   nwords  = {1'b0, head_hi} - {1'b0, head_lo} + 1'b1;
  wire          fire    = (st == XFER) && in_valid && mem_ready;
  wire          last    = fire && (cur == stop_w);
  wire          push_ok = pair_push && !go && (st == IDLE) && (cnt != CW'(DEPTH));
  wire          unused_lsb = ^{pair_lo[1:0], pair_hi[1:0]};

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy       = st != IDLE;
  assign pairs_left = cnt;
  assign mem_valid  = (st == XFER) && in_valid;
  assign in_ready   = (st == XFER) && mem_ready;
  assign mem_addr   = {cur, 2'b00};
  assign mem_data   = in_data;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      q_lo[wr_p] <= pair_lo[AW-1:2];
      q_hi[wr_p] <= pair_hi[AW-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; rd_p <= '0; wr_p <= '0; cnt <= '0;
      irq <= 1'b0; err_empty <= 1'b0; err_range <= 1'b0;
      cur <= '0; stop_w <= '0; win_bytes <= '0;
    end else begin
      if (push_ok) begin
        wr_p <= nxt(wr_p);
        cnt  <= cnt + 1'b1;
      end
      case (st)
        IDLE: if (go) begin
          irq <= 1'b0; err_range <= 1'b0;
          err_empty <= (cnt == '0);
          if (cnt != '0) st <= LOAD;
        end
        LOAD: if (bad) begin
          err_range <= 1'b1; st <= IDLE;
          cnt <= '0; rd_p <= '0; wr_p <= '0;
        end else begin
          cur <= head_lo; stop_w <= head_hi;
          win_bytes <= {nwords, 2'b00};
          rd_p <= nxt(rd_p); cnt <= cnt - 1'b1;
          st <= XFER;
        end
        XFER: if (fire) begin
          cur <= cur + 1'b1;
          if (last) begin
            if (cnt == '0) begin st <= IDLE; irq <= 1'b1; end
            else st <= LOAD;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !in_ready));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (mem_addr == $past(mem_addr) + AW'(4)));
  // R3
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[AW-1:2] <= stop_w));
  // R2
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pairs_left <= CW'(DEPTH));
  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);
  // R8
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_empty) |-> (!busy && pairs_left == '0));
endmodule

// File: tb/ptr_dma_tb.sv
module ptr_dma_tb_top;
  logic clk = 0, rst_n = 0;
  logic pair_push = 0, go = 0, in_valid = 0, stall = 0;
  logic [23:0] pair_lo = 0, pair_hi = 0;
  logic busy, irq, err_empty, err_range, in_ready, mem_valid, mem_ready;
  logic [3:0] pairs_left;
  logic [24:0] win_bytes;
  logic [31:0] in_data, mem_data, seq = 0;
  logic [23:0] mem_addr;
  int cyc = 0, nlog = 0, errors = 0, checks = 0;
  logic [23:0] log_addr [64];
  logic [31:0] log_data [64];
  int log_cyc [64];

  always #4 clk = ~clk;
  assign in_data   = seq;
  assign mem_ready = stall ? (cyc % 3 != 0) : 1'b1;

  ptr_dma dut_i (.clk(clk), .rst_n(rst_n), .pair_push(pair_push), .pair_lo(pair_lo),
    .pair_hi(pair_hi), .go(go), .busy(busy), .irq(irq), .err_empty(err_empty),
    .err_range(err_range), .pairs_left(pairs_left), .win_bytes(win_bytes),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) seq <= seq + 1;
    if (mem_valid && mem_ready && nlog < 64) begin
      log_addr[nlog] <= mem_addr; log_data[nlog] <= mem_data;
      log_cyc[nlog] <= cyc; nlog <= nlog + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] lo, input logic [23:0] hi);
    pair_lo = lo; pair_hi = hi; pair_push = 1;
    @(negedge clk); pair_push = 0;
  endtask

  task automatic pulse_go();
    go = 1; @(negedge clk); go = 0;
  endtask

  task automatic wait_words(input int target);
    for (int t = 0; t < 3000 && nlog < target; t++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0);
    chk("R1 errs", {err_empty, err_range}, 0); chk("R1 pairs_left", pairs_left, 0);
    chk("R1 R4 handshake", {mem_valid, in_ready}, 0);
  endtask

  task automatic t_order_gap();
    int base = nlog;
    for (int i = 0; i < 9; i++) push(24'h40 + 24'(8 * i), 24'h40 + 24'(8 * i));
    chk("R2 full queue", pairs_left, 8);
    in_valid = 1; pulse_go();
    wait_words(base + 8);
    chk("R7 irq with last word", {irq, busy}, 2'b10);
    for (int i = 0; i < 8; i++) begin
      chk("R5 pair order", log_addr[base + i], 24'h40 + 24'(8 * i));
      if (i > 0) chk("R5 one idle cycle", log_cyc[base + i] - log_cyc[base + i - 1], 2);
    end
    in_valid = 0;
  endtask

  task automatic t_split();
    int base = nlog;
    logic [31:0] d0 = seq;
    logic [23:0] exp_a [12];
    for (int i = 0; i < 2; i++) exp_a[i] = 24'h100 + 24'(4 * i);
    for (int i = 0; i < 4; i++) exp_a[2 + i] = 24'h1000 + 24'(4 * i);
    for (int i = 0; i < 2; i++) exp_a[6 + i] = 24'h108 + 24'(4 * i);
    for (int i = 0; i < 4; i++) exp_a[8 + i] = 24'h1010 + 24'(4 * i);
    push(24'h100, 24'h104); push(24'h1000, 24'h100C);
    push(24'h108, 24'h10C); push(24'h1010, 24'h101C);
    stall = 1; in_valid = 1; pulse_go();
    repeat (4) @(negedge clk);
    push(24'h500, 24'h500);
    pulse_go();
    wait_words(base + 12);
    repeat (6) @(negedge clk);
    chk("R6 word count", nlog - base, 12);
    for (int i = 0; i < 12; i++) begin
      chk("R6 R3 address", log_addr[base + i], exp_a[i]);
      chk("R3 R4 data order", log_data[base + i], d0 + 32'(i));
    end
    chk("R2 push while busy", pairs_left, 0);
    chk("R11 go while busy", {irq, busy}, 2'b10);
    stall = 0; in_valid = 0;
  endtask

  task automatic t_empty();
    int base = nlog;
    pulse_go();
    chk("R8 err_empty", {err_empty, busy}, 2'b10);
    chk("R11 go clears irq", irq, 0);
    repeat (3) @(negedge clk);
    chk("R8 no transfer", nlog - base, 0);
  endtask

  task automatic t_range();
    int base = nlog;
    push(24'h200, 24'h1FC); push(24'h300, 24'h300);
    in_valid = 1; pulse_go();
    repeat (3) @(negedge clk);
    chk("R9 err_range", {err_range, busy}, 2'b10);
    chk("R9 queue cleared", pairs_left, 0);
    chk("R9 no transfer", nlog - base, 0);
    chk("R11 go clears err_empty", err_empty, 0);
    in_valid = 0;
    pulse_go();
    chk("R11 go clears err_range", err_range, 0);
  endtask

  task automatic t_window();
    int base = nlog;
    push(24'h400, 24'h400);
    pulse_go(); @(negedge clk);
    chk("R10 single word window", win_bytes, 4);
    chk("R4 no valid without input", mem_valid, 0);
    in_valid = 1;
    wait_words(base + 1);
    chk("R3 single word addr", log_addr[base], 24'h400);
    chk("R7 single block irq", {irq, busy}, 2'b10);
    in_valid = 0;
    push(24'h0, 24'hFFFFFC);
    pulse_go(); @(negedge clk);
    chk("R10 full window", win_bytes, 25'h1000000);
    rst_n = 0; @(negedge clk); rst_n = 1;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_order_gap();
    t_split();
    t_empty();
    t_range();
    t_window();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule